// File: doc/BRIEF.md
# Flash whole-array erase sequencer

This block drives a complete erase of a byte-wide flash array that uses a command-driven internal state machine. When started, it switches on the programming supply and waits a settle time. It then walks every address in ascending order and programs each byte to 00h. For each byte it repeats a program pulse and a program-verify read until the byte reads back zero, up to a bounded number of tries. Only after every byte holds zero does it begin erasing. The erase is pulsed. After each chip-wide erase pulse, an erase-verify scan walks the addresses and stops at the first byte that does not yet read FFh. The next pulse is followed by a scan that picks up at that same address, not at address zero.

The run ends in one of three ways. It completes when the last address reads FFh. It fails if a byte will not program within the pulse limit. It also fails if the erase pulse count reaches its ceiling. In every case the supply is switched off and allowed to fall before the result is flagged. The array depth, all delays (as cycle counts), both pulse limits and all five command codes are parameters.

Top module: `fes_erase_seq`

## Requirements
- R1: Reset state. While reset is high and on the cycle after it, busy, done, fail, vpp_en, flash_we and flash_re are 0, and phase and erase_count are 0.
- R2: Supply ramp-up. A start seen while idle or finished raises vpp_en. vpp_en stays high for exactly VPP_SETTLE cycles before the first flash write. No flash write ever happens while vpp_en is low.
- R3: Zero pre-program. Each address is handled in ascending order. A write of PGM_SETUP is followed by a write of data 00h to the same address. The bench counts each such 00h write as one program pulse. Next comes a program-verify write, issued PGM_PULSE+1 cycles after the data write, and then a read. These steps repeat until the read returns 00h. The total number of 00h data writes equals the sum of the pulses each byte needs.
- R4: Pre-program limit. A byte that still does not read 00h after PGM_MAX data writes ends the run with fail=1 and phase=1. No erase command is issued and erase_count stays 0. A byte needing exactly PGM_MAX pulses still passes.
- R5: No erase command (ERASE_SETUP followed by ERASE_CONFIRM) is issued before every address has verified as 00h.
- R6: Erase pulse. Each pulse is a write of ERASE_SETUP followed by a write of ERASE_CONFIRM. erase_count increments by one for each pulse. The next write (ERASE_VERIFY) comes exactly ERASE_PULSE+1 cycles after the confirm write.
- R7: Resuming verify. Each erase-verify is a write of ERASE_VERIFY to the address, then a read. A read returning FFh advances the address. Any other value triggers a new pulse, and the scan then resumes at the same address. Verify addresses therefore never decrease within a run. A run that needs P pulses makes exactly DEPTH+P-1 verify reads.
- R8: Success. When the last address reads FFh, the run ends with done=1, fail=0 and phase=3. erase_count equals the number of pulses used, which is the largest per-byte requirement.
- R9: Erase limit. If a verify read fails when erase_count equals ERASE_MAX, the run ends with fail=1 and phase=2. erase_count then equals ERASE_MAX.
- R10: Supply ramp-down. At the end of any run, vpp_en falls, and done or fail rises exactly VPP_SETTLE cycles later. busy stays high until then.
- R11: A start pulse while busy has no effect. Results and counts are the same as in a run without it.
- R12: Restart. A start while finished clears done and fail, raises busy on the next cycle, and restarts erase_count from zero. While finished with no start, erase_count holds its value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Begin a whole-array erase |
| vpp_en | output | 1 | Programming-supply enable |
| flash_we | output | 1 | Flash write strobe (command or data) |
| flash_re | output | 1 | Flash read strobe |
| flash_addr | output | clog2(DEPTH) | Flash byte address |
| flash_wdata | output | 8 | Command or data byte written |
| flash_rdata | input | 8 | Read data, valid the cycle after flash_re |
| busy | output | 1 | A run is in progress |
| done | output | 1 | Run finished with every byte erased |
| fail | output | 1 | Run aborted on a pulse limit |
| phase | output | 2 | 0 power-up/idle, 1 pre-program, 2 erase, 3 complete |
| erase_count | output | clog2(ERASE_MAX+1) | Erase pulses applied in this run |

## Verification
A verify pointer that is wrongly reset after a pulse shows at once as a drop in flash_addr during the erase phase, and in the total number of verify reads at the end of the run. A pulse or limit counter that is off by one shows as a wrong erase_count or as the wrong outcome when a byte sits exactly at a limit. Timer faults show within one pulse as a wrong gap between the confirm or data write and the next command write, or in the supply ramp windows. A phase-ordering fault shows as an erase command issued while some byte is still unprogrammed.

// File: rtl/fes_pkg.sv
package fes_pkg;

    typedef enum logic [3:0] {
        S_IDLE,
        S_RAMP_UP,
        S_P_SETUP,
        S_P_DATA,
        S_P_WAIT,
        S_P_VCMD,
        S_P_READ,
        S_P_CHK,
        S_E_SETUP,
        S_E_CONF,
        S_E_WAIT,
        S_E_VCMD,
        S_E_READ,
        S_E_CHK,
        S_RAMP_DOWN,
        S_END
    } seq_state_e;

    typedef enum logic [1:0] {
        PH_POWER = 2'd0,
        PH_ZERO  = 2'd1,
        PH_ERASE = 2'd2,
        PH_CLEAN = 2'd3
    } phase_e;

    typedef struct packed {
        logic       wr;
        logic       rd;
        logic [7:0] data;
    } bus_op_t;

    localparam logic [7:0] BYTE_ZERO = 8'h00;
    localparam logic [7:0] BYTE_ONES = 8'hFF;

    function automatic int unsigned max3(int unsigned a, int unsigned b, int unsigned c);
        int unsigned m;
        m = (a > b) ? a : b;
        return (m > c) ? m : c;
    endfunction

endpackage

// File: rtl/fes_delay.sv
module fes_delay #(
    parameter int unsigned TW = 8
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          load,
    input  logic [TW-1:0] value,
    output logic          zero
);
    logic [TW-1:0] cnt;

    always_ff @(posedge clk) begin
        if (rst)              cnt <= '0;
        else if (load)        cnt <= value;
        else if (cnt != '0)   cnt <= cnt - 1'b1;
    end

    assign zero = (cnt == '0);

    // R6: once expired, the timer stays expired until reloaded
    p_timer_hold_r6: assert property (@(posedge clk) disable iff (rst)
        (zero && !load) |=> zero);

endmodule

// File: rtl/fes_addr_walk.sv
module fes_addr_walk #(
    parameter int unsigned DEPTH = 16,
    parameter int unsigned AW    = 4
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          clr,
    input  logic          step,
    output logic [AW-1:0] addr,
    output logic          last
);
    localparam logic [AW-1:0] TOP = AW'(DEPTH - 1);

    always_ff @(posedge clk) begin
        if (rst || clr)          addr <= '0;
        else if (step && !last)  addr <= addr + 1'b1;
    end

    assign last = (addr == TOP);

    // R7: the pointer never leaves the array
    p_addr_range_r7: assert property (@(posedge clk) disable iff (rst)
        addr <= TOP);

    // R7: without a clear the pointer only moves forward
    p_addr_forward_r7: assert property (@(posedge clk) disable iff (rst)
        !clr |=> addr >= $past(addr));

endmodule

// File: rtl/fes_pulse_tally.sv
module fes_pulse_tally #(
    parameter int unsigned LIMIT = 25,
    parameter int unsigned W     = 5
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         clr,
    input  logic         bump,
    output logic [W-1:0] count,
    output logic         at_limit
);
    localparam logic [W-1:0] CAP = W'(LIMIT);

    always_ff @(posedge clk) begin
        if (rst || clr)              count <= '0;
        else if (bump && !at_limit)  count <= count + 1'b1;
    end

    assign at_limit = (count == CAP);

    // R9: a tally never passes its limit
    p_tally_cap_r9: assert property (@(posedge clk) disable iff (rst)
        count <= CAP);

endmodule

// File: rtl/fes_erase_seq.sv
module fes_erase_seq
    import fes_pkg::*;
#(
    parameter int unsigned DEPTH        = 131072,
    parameter int unsigned VPP_SETTLE   = 250000,
    parameter int unsigned PGM_PULSE    = 500,
    parameter int unsigned ERASE_PULSE  = 500000,
    parameter int unsigned PGM_MAX      = 25,
    parameter int unsigned ERASE_MAX    = 3000,
    parameter logic [7:0]  PGM_SETUP    = 8'h40,
    parameter logic [7:0]  PGM_VERIFY   = 8'hC0,
    parameter logic [7:0]  ERASE_SETUP  = 8'h20,
    parameter logic [7:0]  ERASE_CONFIRM = 8'h20,
    parameter logic [7:0]  ERASE_VERIFY = 8'hA0,
    localparam int unsigned AW = $clog2(DEPTH),
    localparam int unsigned EW = $clog2(ERASE_MAX + 1)
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          start,
    output logic          vpp_en,
    output logic          flash_we,
    output logic          flash_re,
    output logic [AW-1:0] flash_addr,
    output logic [7:0]    flash_wdata,
    input  logic [7:0]    flash_rdata,
    output logic          busy,
    output logic          done,
    output logic          fail,
    output logic [1:0]    phase,
    output logic [EW-1:0] erase_count
);
    localparam int unsigned PW = $clog2(PGM_MAX + 1);
    localparam int unsigned TW = $clog2(max3(VPP_SETTLE, PGM_PULSE, ERASE_PULSE) + 1);
    localparam logic [TW-1:0] VPP_LD = TW'(VPP_SETTLE - 1);
    localparam logic [TW-1:0] PGM_LD = TW'(PGM_PULSE - 1);
    localparam logic [TW-1:0] ERS_LD = TW'(ERASE_PULSE - 1);

    seq_state_e state, nxt;
    phase_e     phase_q, phase_nxt;
    logic       fail_q, fail_nxt;
    bus_op_t    bus;

    logic          tmr_ld, tmr_zero;
    logic [TW-1:0] tmr_val;
    logic          a_clr, a_step, a_last;
    logic          p_clr, p_bump, p_hit;
    logic [PW-1:0] p_count;
    logic          e_clr, e_bump, e_hit;

    fes_delay #(.TW(TW)) u_delay (
        .clk(clk), .rst(rst), .load(tmr_ld), .value(tmr_val), .zero(tmr_zero)
    );

    fes_addr_walk #(.DEPTH(DEPTH), .AW(AW)) u_addr (
        .clk(clk), .rst(rst), .clr(a_clr), .step(a_step),
        .addr(flash_addr), .last(a_last)
    );

    fes_pulse_tally #(.LIMIT(PGM_MAX), .W(PW)) u_pgm_tally (
        .clk(clk), .rst(rst), .clr(p_clr), .bump(p_bump),
        .count(p_count), .at_limit(p_hit)
    );

    fes_pulse_tally #(.LIMIT(ERASE_MAX), .W(EW)) u_ers_tally (
        .clk(clk), .rst(rst), .clr(e_clr), .bump(e_bump),
        .count(erase_count), .at_limit(e_hit)
    );

    always_comb begin
        nxt       = state;
        phase_nxt = phase_q;
        fail_nxt  = fail_q;
        bus       = '0;
        tmr_ld    = 1'b0;
        tmr_val   = '0;
        a_clr     = 1'b0;
        a_step    = 1'b0;
        p_clr     = 1'b0;
        p_bump    = 1'b0;
        e_clr     = 1'b0;
        e_bump    = 1'b0;
        case (state)
            S_IDLE, S_END: begin
                if (start) begin
                    nxt       = S_RAMP_UP;
                    tmr_ld    = 1'b1;
                    tmr_val   = VPP_LD;
                    a_clr     = 1'b1;
                    p_clr     = 1'b1;
                    e_clr     = 1'b1;
                    phase_nxt = PH_POWER;
                    fail_nxt  = 1'b0;
                end
            end
            S_RAMP_UP: begin
                if (tmr_zero) begin
                    nxt       = S_P_SETUP;
                    phase_nxt = PH_ZERO;
                end
            end
            S_P_SETUP: begin
                bus.wr   = 1'b1;
                bus.data = PGM_SETUP;
                nxt      = S_P_DATA;
            end
            S_P_DATA: begin
                bus.wr   = 1'b1;
                bus.data = BYTE_ZERO;
                p_bump   = 1'b1;
                tmr_ld   = 1'b1;
                tmr_val  = PGM_LD;
                nxt      = S_P_WAIT;
            end
            S_P_WAIT: begin
                if (tmr_zero) nxt = S_P_VCMD;
            end
            S_P_VCMD: begin
                bus.wr   = 1'b1;
                bus.data = PGM_VERIFY;
                nxt      = S_P_READ;
            end
            S_P_READ: begin
                bus.rd = 1'b1;
                nxt    = S_P_CHK;
            end
            S_P_CHK: begin
                if (flash_rdata == BYTE_ZERO) begin
                    p_clr = 1'b1;
                    if (a_last) begin
                        a_clr     = 1'b1;
                        phase_nxt = PH_ERASE;
                        nxt       = S_E_SETUP;
                    end else begin
                        a_step = 1'b1;
                        nxt    = S_P_SETUP;
                    end
                end else if (p_hit) begin
                    fail_nxt = 1'b1;
                    tmr_ld   = 1'b1;
                    tmr_val  = VPP_LD;
                    nxt      = S_RAMP_DOWN;
                end else begin
                    nxt = S_P_SETUP;
                end
            end
            S_E_SETUP: begin
                bus.wr   = 1'b1;
                bus.data = ERASE_SETUP;
                nxt      = S_E_CONF;
            end
            S_E_CONF: begin
                bus.wr   = 1'b1;
                bus.data = ERASE_CONFIRM;
                e_bump   = 1'b1;
                tmr_ld   = 1'b1;
                tmr_val  = ERS_LD;
                nxt      = S_E_WAIT;
            end
            S_E_WAIT: begin
                if (tmr_zero) nxt = S_E_VCMD;
            end
            S_E_VCMD: begin
                bus.wr   = 1'b1;
                bus.data = ERASE_VERIFY;
                nxt      = S_E_READ;
            end
            S_E_READ: begin
                bus.rd = 1'b1;
                nxt    = S_E_CHK;
            end
            S_E_CHK: begin
                if (flash_rdata == BYTE_ONES) begin
                    if (a_last) begin
                        phase_nxt = PH_CLEAN;
                        tmr_ld    = 1'b1;
                        tmr_val   = VPP_LD;
                        nxt       = S_RAMP_DOWN;
                    end else begin
                        a_step = 1'b1;
                        nxt    = S_E_VCMD;
                    end
                end else if (e_hit) begin
                    fail_nxt = 1'b1;
                    tmr_ld   = 1'b1;
                    tmr_val  = VPP_LD;
                    nxt      = S_RAMP_DOWN;
                end else begin
                    nxt = S_E_SETUP;
                end
            end
            S_RAMP_DOWN: begin
                if (tmr_zero) nxt = S_END;
            end
            default: nxt = S_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state   <= S_IDLE;
            phase_q <= PH_POWER;
            fail_q  <= 1'b0;
        end else begin
            state   <= nxt;
            phase_q <= phase_nxt;
            fail_q  <= fail_nxt;
        end
    end

    assign flash_we    = bus.wr;
    assign flash_re    = bus.rd;
    assign flash_wdata = bus.data;
    assign vpp_en      = !(state inside {S_IDLE, S_RAMP_DOWN, S_END});
    assign busy        = !(state inside {S_IDLE, S_END});
    assign done        = (state == S_END) && !fail_q;
    assign fail        = (state == S_END) && fail_q;
    assign phase       = phase_q;

    // R2: flash writes only happen with the supply on
    p_write_needs_vpp_r2: assert property (@(posedge clk) disable iff (rst)
        flash_we |-> vpp_en);

    // R3: read and write strobes never overlap
    p_no_rw_overlap_r3: assert property (@(posedge clk) disable iff (rst)
        !(flash_we && flash_re));

    // R4: no erase pulse is counted during pre-program
    p_no_erase_in_zero_r4: assert property (@(posedge clk) disable iff (rst)
        (busy && phase == 2'd1) |-> erase_count == '0);

    // R4: program tally stays within its limit
    p_pgm_cap_r4: assert property (@(posedge clk) disable iff (rst)
        p_count <= PW'(PGM_MAX));

    // R8: completion reports phase 3 with the supply off
    p_done_clean_r8: assert property (@(posedge clk) disable iff (rst)
        done |-> (phase == 2'd3 && !vpp_en && !fail));

    // R9: failure is tagged with the phase that failed
    p_fail_phase_r9: assert property (@(posedge clk) disable iff (rst)
        fail |-> (phase == 2'd1 || phase == 2'd2));

    // R10: busy covers the supply fall
    p_busy_until_end_r10: assert property (@(posedge clk) disable iff (rst)
        (busy && !vpp_en) |=> (busy || done || fail));

    // R12: a finished result holds until the next start
    p_hold_result_r12: assert property (@(posedge clk) disable iff (rst)
        ((done || fail) && !start) |=> ($stable(erase_count) && (done || fail)));

endmodule

// File: tb/sim_fes_erase_seq.sv
module sim_fes_erase_seq;

    localparam int CLK_PERIOD = 10;
    localparam int DEPTH      = 16;
    localparam int AW         = 4;
    localparam int VPP        = 5;
    localparam int PP         = 3;
    localparam int EP         = 4;
    localparam int PMAX       = 25;
    localparam int EMAX       = 3000;
    localparam int EW         = $clog2(EMAX + 1);
    localparam int WATCHDOG   = 190000;
    localparam logic [7:0] C_PS = 8'h40, C_PV = 8'hC0, C_ES = 8'h20, C_EC = 8'h20, C_EV = 8'hA0;

    typedef struct packed {
        logic [15:0] pbase;
        logic [15:0] pspan;
        logic [15:0] ebase;
        logic [15:0] espan;
        logic [1:0]  want;   // 0 done, 1 pre-program fail, 2 erase fail
    } scen_t;

    localparam int NSC = 6;
    localparam scen_t TABLE [NSC] = '{
        '{16'd1,  16'd1, 16'd1,    16'd1,  2'd0},
        '{16'd1,  16'd3, 16'd50,   16'd20, 2'd0},
        '{16'd2,  16'd4, 16'd180,  16'd40, 2'd0},
        '{16'd26, 16'd1, 16'd1,    16'd1,  2'd1},
        '{16'd1,  16'd1, 16'd3001, 16'd1,  2'd2},
        '{16'd24, 16'd2, 16'd7,    16'd9,  2'd0}
    };

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          start = 1'b0;
    logic          vpp_en, flash_we, flash_re, busy, done, fail;
    logic [AW-1:0] flash_addr;
    logic [7:0]    flash_wdata;
    logic [7:0]    flash_rdata = 8'h00;
    logic [1:0]    phase;
    logic [EW-1:0] erase_count;

    fes_erase_seq #(
        .DEPTH(DEPTH), .VPP_SETTLE(VPP), .PGM_PULSE(PP), .ERASE_PULSE(EP),
        .PGM_MAX(PMAX), .ERASE_MAX(EMAX),
        .PGM_SETUP(C_PS), .PGM_VERIFY(C_PV), .ERASE_SETUP(C_ES),
        .ERASE_CONFIRM(C_EC), .ERASE_VERIFY(C_EV)
    ) u0 (
        .clk(clk), .rst(rst), .start(start), .vpp_en(vpp_en),
        .flash_we(flash_we), .flash_re(flash_re), .flash_addr(flash_addr),
        .flash_wdata(flash_wdata), .flash_rdata(flash_rdata),
        .busy(busy), .done(done), .fail(fail), .phase(phase),
        .erase_count(erase_count)
    );

    always #(CLK_PERIOD / 2) clk = ~clk;

    int checks = 0;
    int errors = 0;
    int cyc = 0;

    // flash model and bus monitor state
    int   need_p [DEPTH];
    int   need_e [DEPTH];
    int   hits   [DEPTH];
    bit   zeroed [DEPTH];
    logic [7:0] last_cmd = 8'h00;
    int   m_pulses, prog_writes, ev_reads;
    int   order_bad, back_bad, early_bad, pw_bad, ew_bad, unpowered_wr;
    int   last_pd_addr, last_ev_addr;
    int   t_pd, t_conf;
    bit   pend_pd, pend_conf;
    bit   first_wr, prev_vpp, down_arm;
    int   up_cyc, down_cyc;

    task automatic model_clear();
        m_pulses = 0; prog_writes = 0; ev_reads = 0;
        order_bad = 0; back_bad = 0; early_bad = 0; pw_bad = 0; ew_bad = 0; unpowered_wr = 0;
        last_pd_addr = 0; last_ev_addr = 0; t_pd = 0; t_conf = 0;
        pend_pd = 0; pend_conf = 0; first_wr = 0; down_arm = 0;
        up_cyc = 0; down_cyc = 0; last_cmd = 8'h00;
        for (int a = 0; a < DEPTH; a++) begin
            hits[a] = 0;
            zeroed[a] = 0;
        end
    endtask

    always @(negedge clk) begin
        cyc++;
        if (vpp_en && !first_wr && !flash_we) up_cyc++;
        if (prev_vpp && !vpp_en) begin
            down_arm = 1;
            down_cyc = 0;
        end
        if (down_arm && !vpp_en && !done && !fail) down_cyc++;
        if (done || fail) down_arm = 0;
        prev_vpp = vpp_en;

        if (flash_we) begin
            first_wr = 1;
            if (!vpp_en) unpowered_wr++;
            if (pend_pd) begin
                if (cyc - t_pd != PP + 1) pw_bad++;
                pend_pd = 0;
            end
            if (pend_conf) begin
                if (cyc - t_conf != EP + 1 || flash_wdata != C_EV) ew_bad++;
                pend_conf = 0;
            end
            if (last_cmd == C_PS) begin
                prog_writes++;
                if (int'(flash_addr) < last_pd_addr) order_bad++;
                last_pd_addr = int'(flash_addr);
                hits[flash_addr]++;
                if (hits[flash_addr] >= need_p[flash_addr]) zeroed[flash_addr] = 1;
                t_pd = cyc; pend_pd = 1;
                last_cmd = 8'h00;
            end else if (last_cmd == C_ES && flash_wdata == C_EC) begin
                m_pulses++;
                for (int a = 0; a < DEPTH; a++) if (!zeroed[a]) early_bad++;
                t_conf = cyc; pend_conf = 1;
                last_cmd = 8'h00;
            end else begin
                last_cmd = flash_wdata;
            end
        end
        if (flash_re) begin
            if (last_cmd == C_PV) begin
                flash_rdata <= zeroed[flash_addr] ? 8'h00 : 8'hFF;
            end else if (last_cmd == C_EV) begin
                ev_reads++;
                if (int'(flash_addr) < last_ev_addr) back_bad++;
                last_ev_addr = int'(flash_addr);
                flash_rdata <= (m_pulses >= need_e[flash_addr]) ? 8'hFF : 8'h00;
            end else begin
                flash_rdata <= 8'h5A;
            end
        end
    end

    task automatic chk(bit ok, string req, string what, int act, int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    task automatic finish_run();
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    endtask

    always @(negedge clk) begin
        if (cyc > WATCHDOG) begin
            errors++;
            $display("FAIL watchdog: actual %0d expected %0d", cyc, WATCHDOG);
            finish_run();
        end
    end

    // expected outcome computed from the requirements
    int x_want, x_prog, x_pulses, x_reads;

    task automatic expect_run();
        int ptr, pl;
        x_want = 0; x_prog = 0; x_pulses = 0; x_reads = 0;
        for (int a = 0; a < DEPTH; a++) begin
            if (need_p[a] > PMAX) begin
                x_prog += PMAX;
                x_want = 1;
                break;
            end
            x_prog += need_p[a];
        end
        if (x_want == 0) begin
            ptr = 0; pl = 1;
            for (int guard = 0; guard < 100000; guard++) begin
                x_reads++;
                if (pl >= need_e[ptr]) begin
                    if (ptr == DEPTH - 1) break;
                    ptr++;
                end else if (pl == EMAX) begin
                    x_want = 2;
                    break;
                end else begin
                    pl++;
                end
            end
            x_pulses = pl;
        end
    endtask

    task automatic run_case(int idx, bit extra_start, string tag);
        scen_t s;
        int wait_n;
        s = TABLE[idx];
        for (int a = 0; a < DEPTH; a++) begin
            need_p[a] = int'(s.pbase) + (a * 7 + idx) % int'(s.pspan);
            need_e[a] = int'(s.ebase) + (a * 5) % int'(s.espan);
        end
        @(negedge clk);
        model_clear();
        expect_run();
        chk(x_want == int'(s.want), "R8", {tag, " table outcome"}, x_want, int'(s.want));
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        chk(busy && !done && !fail, "R12", {tag, " busy after start"}, int'(busy), 1);
        wait_n = 0;
        while (!(done || fail) && wait_n < 60000) begin
            @(negedge clk);
            wait_n++;
            if (extra_start && (wait_n == 3 || wait_n == 200 || wait_n == 900)) start = 1'b1;
            else start = 1'b0;
        end
        start = 1'b0;
        chk(done == (x_want == 0), "R8", {tag, " done"}, int'(done), int'(x_want == 0));
        chk(fail == (x_want != 0), "R9", {tag, " fail"}, int'(fail), int'(x_want != 0));
        chk(!busy && !vpp_en, "R10", {tag, " idle at end"}, int'(busy), 0);
        if (x_want == 0)
            chk(phase == 2'd3, "R8", {tag, " phase"}, int'(phase), 3);
        else if (x_want == 1)
            chk(phase == 2'd1, "R4", {tag, " phase"}, int'(phase), 1);
        else
            chk(phase == 2'd2, "R9", {tag, " phase"}, int'(phase), 2);
        chk(int'(erase_count) == x_pulses, "R6", {tag, " erase_count"}, int'(erase_count), x_pulses);
        chk(m_pulses == x_pulses, "R6", {tag, " erase commands"}, m_pulses, x_pulses);
        chk(prog_writes == x_prog, "R3", {tag, " program pulses"}, prog_writes, x_prog);
        chk(order_bad == 0, "R3", {tag, " ascending program"}, order_bad, 0);
        chk(pw_bad == 0, "R3", {tag, " program pulse width"}, pw_bad, 0);
        chk(ev_reads == x_reads, "R7", {tag, " verify reads"}, ev_reads, x_reads);
        chk(back_bad == 0, "R7", {tag, " verify pointer resumes"}, back_bad, 0);
        chk(early_bad == 0, "R5", {tag, " erase before zeroed"}, early_bad, 0);
        chk(ew_bad == 0, "R6", {tag, " erase pulse width"}, ew_bad, 0);
        chk(up_cyc == VPP, "R2", {tag, " ramp-up cycles"}, up_cyc, VPP);
        chk(unpowered_wr == 0, "R2", {tag, " write without supply"}, unpowered_wr, 0);
        chk(down_cyc == VPP, "R10", {tag, " ramp-down cycles"}, down_cyc, VPP);
        repeat (3) @(negedge clk);
        chk(int'(erase_count) == x_pulses && (done || fail), "R12", {tag, " result held"},
            int'(erase_count), x_pulses);
    endtask

    initial begin
        model_clear();
        prev_vpp = 0;
        repeat (3) @(negedge clk);
        // R1: reset state
        chk(!busy && !done && !fail && !vpp_en, "R1", "flags in reset", int'(busy | done | fail | vpp_en), 0);
        chk(!flash_we && !flash_re && phase == 2'd0 && erase_count == '0, "R1", "bus and counts in reset",
            int'(erase_count), 0);
        rst = 1'b0;
        @(negedge clk);
        chk(!busy && !vpp_en && !flash_we, "R1", "idle after reset", int'(busy), 0);

        for (int i = 0; i < NSC; i++) begin
            string tag;
            tag = $sformatf("case%0d", i);
            run_case(i, 1'b0, tag);
        end

        // R11: start pulses during a run change nothing
        run_case(1, 1'b1, "r11_rerun");

        // R1: reset in the middle of a run
        need_p[0] = 1;
        @(negedge clk);
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        repeat (20) @(negedge clk);
        rst = 1'b1;
        repeat (2) @(negedge clk);
        chk(!busy && !vpp_en && !done && !fail, "R1", "mid-run reset flags", int'(busy), 0);
        chk(phase == 2'd0 && erase_count == '0, "R1", "mid-run reset counts", int'(phase), 0);
        rst = 1'b0;
        @(negedge clk);

        // R12: restart after a mid-run reset still works
        run_case(0, 1'b0, "r12_restart");

        finish_run();
    end

endmodule